// File: doc/BRIEF.md
# Interprocessor Command Dispatcher

This block sits behind the write port of a 64-bit interprocessor command register held as two 32-bit words. Software, or a bus adapter in front of it, writes the high word to choose a destination and then writes the low word to fire a message. The block decodes the low word, works out which processing units the message goes to, and hands a dispatch request downstream. The request carries the vector, the delivery mode, the trigger mode and the destination bitmask. The transport that carries the message, and the choice of a single target for lowest-priority delivery, belong to the consumer of that request.

Destinations are resolved in one of three ways. In physical mode the field names one unit by its index, or all units with the value 0xFF. In logical mode each unit's 8-bit logical ID is matched against the field. A two-bit shorthand replaces either method with self, all, or all-but-self. The result is then reduced to units that are both present and local. When a mode cannot be delivered, or when no destination remains, the block pulses an error strobe for the error-status register and sends nothing.

Both the register write port and the dispatch output use valid/ready. A write is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for as long as a dispatch request is waiting, so a new send can never overwrite a request that has not been taken. The dispatch output holds `disp_valid` and its payload unchanged until the cycle in which `disp_ready` is high.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After a synchronous reset, `disp_valid`, `mode_stb`, both error strobes, the dispatch payload and both stored words are zero, and `wr_ready` is 1.
- R2: Low-word fields are: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11 (1 = logical), trigger mode in bit 15, and shorthand in bits 19:18. A low-word write that is accepted and supported raises `disp_valid` on the next cycle, with `disp_vector`, `disp_mode` and `disp_trig` taken from those bits.
- R3: An accepted low-word write stores the word with bit 12 cleared, and `cmd_lo_q` shows it from the next cycle. An accepted high-word write only stores the word in `cmd_hi_q`, whose bits 31:24 are the destination field. It starts no dispatch and raises no error.
- R4: In physical mode with shorthand 0, destination 0xFF selects every unit, and any other value v selects only unit v; a value at or above the unit count selects none.
- R5: In logical mode with shorthand 0, destination 0 selects no unit. Any other value selects each unit whose logical ID (byte i of `unit_ldr`) shares at least one set bit with it.
- R6: Shorthand 1 selects only unit `self_id`, 2 selects all units, and 3 selects all units except `self_id`. In each of these cases the destination field and destination mode are ignored.
- R7: The mask that is sent has a bit set only for a unit whose `unit_present` and `unit_local` bits are both 1.
- R8: When the mode is supported but the pruned mask is empty, `err_tx_accept` is high for exactly one cycle, the cycle after the write, and `disp_valid` stays low.
- R9: Delivery modes 2, 3 and 7 are unsupported. Writing one of them raises `err_bad_mode` for one cycle after the write, leaves `disp_valid` and `err_tx_accept` low, and still stores the low word. Modes 0, 1, 4, 5 and 6 are supported.
- R10: `mode_stb` is zero except in the first cycle of a dispatch request. In that cycle exactly bit m is set, where m is the delivery mode.
- R11: While `disp_valid` is high and `disp_ready` is low, the request and its payload stay unchanged on the next cycle. `wr_ready` is low whenever `disp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| self_id | input | ID_W | Index of the unit that issues the command |
| unit_present | input | N_UNITS | Per-unit present flag |
| unit_local | input | N_UNITS | Per-unit local-type flag |
| unit_ldr | input | 8*N_UNITS | Logical ID of each unit, byte i for unit i |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_hi | input | 1 | 1 = high word, 0 = low word (fires a send) |
| wr_data | input | 32 | Write data |
| cmd_lo_q | output | 32 | Stored low word |
| cmd_hi_q | output | 32 | Stored high word |
| disp_valid | output | 1 | Dispatch request pending |
| disp_ready | input | 1 | Downstream takes the request |
| disp_vector | output | 8 | Vector of the request |
| disp_mode | output | 3 | Delivery mode of the request |
| disp_trig | output | 1 | Trigger mode of the request |
| disp_mask | output | N_UNITS | Destination bitmask |
| mode_stb | output | 8 | One-hot delivery-mode strobe at launch |
| err_tx_accept | output | 1 | Pulse: send had no destination |
| err_bad_mode | output | 1 | Pulse: unsupported delivery mode |

## Verification
The assertions check on every cycle that a stalled request keeps its payload, that the mode strobe is one-hot and only fires when a request launches, that an unsupported mode or an empty mask produces its own error pulse and no request, that a high-word write stays silent, and that all-but-self never includes the sender. Other behaviour depends on concrete register values and only the bench's scenarios can show it. This includes the exact bitmask for each physical ID, the 0xFF broadcast, logical matching against particular logical IDs, pruning against a particular present/local map, bit-12 clearing in readback, and the order in which a write held back by a stalled request is finally taken.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

  localparam int WORD_W   = 32;
  localparam int DEST_W   = 8;
  localparam int VEC_W    = 8;
  localparam int N_MODES  = 8;
  localparam int DLV_STAT_BIT = 12;
  localparam int DEST_LSB = 24;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_RSV2   = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_RSV7   = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  typedef struct packed {
    short_e            sh;
    logic              trig;
    logic              logical;
    dmode_e            mode;
    logic [VEC_W-1:0]  vec;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.vec     = w[7:0];
    c.mode    = dmode_e'(w[10:8]);
    c.logical = w[11];
    c.trig    = w[15];
    c.sh      = short_e'(w[19:18]);
    return c;
  endfunction

  function automatic logic mode_ok(input dmode_e m);
    return !((m == DM_RSV2) || (m == DM_RSV3) || (m == DM_RSV7));
  endfunction

endpackage

// File: rtl/icr_word_store.sv
module icr_word_store
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic              send_fire,
  output logic [DEST_W-1:0] dest_id
);

  localparam logic [WORD_W-1:0] STAT_CLR = ~(WORD_W'(1) << DLV_STAT_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_fire) begin
      if (wr_hi) hi_q <= wr_data;
      else       lo_q <= wr_data & STAT_CLR;
    end
  end

  assign send_fire = wr_fire && !wr_hi;
  assign dest_id   = hi_q[DEST_LSB +: DEST_W];

  // R3: a low-word write leaves the high word alone
  p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
    send_fire |=> $stable(hi_q));

endmodule

// File: rtl/dest_resolve.sv
module dest_resolve
  import ipi_cmd_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int ID_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  short_e                    sh,
  input  logic                      logical,
  input  logic [DEST_W-1:0]         dest,
  input  logic [ID_W-1:0]           self_id,
  input  logic [N_UNITS-1:0]        present,
  input  logic [N_UNITS-1:0]        is_local,
  input  logic [N_UNITS*DEST_W-1:0] ldr,
  output logic [N_UNITS-1:0]        mask
);

  localparam logic [DEST_W-1:0] BCAST = '1;

  logic [N_UNITS-1:0] self_hot;
  logic [N_UNITS-1:0] field_hit;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    localparam logic [DEST_W-1:0] MY_DEST = DEST_W'(i);
    localparam logic [ID_W-1:0]   MY_ID   = ID_W'(i);
    logic phys_hit;
    logic log_hit;
    logic raw;

    assign self_hot[i] = (self_id == MY_ID);
    assign phys_hit    = (dest == BCAST) || (dest == MY_DEST);
    assign log_hit     = (dest != '0) && (|(dest & ldr[i*DEST_W +: DEST_W]));
    assign field_hit[i] = logical ? log_hit : phys_hit;

    always_comb begin
      unique case (sh)
        SH_NONE:   raw = field_hit[i];
        SH_SELF:   raw = self_hot[i];
        SH_ALL:    raw = 1'b1;
        SH_OTHERS: raw = !self_hot[i];
        default:   raw = 1'b0;
      endcase
    end

    assign mask[i] = raw && present[i] && is_local[i];
  end

  // R6: all-but-self never contains the sender
  p_others_skip_self_r6: assert property (@(posedge clk) disable iff (rst)
    (sh == SH_OTHERS) |-> ((mask & self_hot) == '0));

  // R5: logical destination zero selects nobody
  p_logical_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (sh == SH_NONE && logical && dest == '0) |-> (mask == '0));

endmodule

// File: rtl/dispatch_out.sv
module dispatch_out
  import ipi_cmd_pkg::*;
#(
  parameter int N_UNITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  cmd_t               cmd,
  input  logic [N_UNITS-1:0] mask_in,
  input  logic               ready,
  output logic               valid,
  output logic [VEC_W-1:0]   vec,
  output logic [2:0]         mode,
  output logic               trig,
  output logic [N_UNITS-1:0] mask_q,
  output logic [N_MODES-1:0] stb,
  output logic               err_empty,
  output logic               err_mode
);

  logic good_mode;
  logic has_dest;
  logic go;

  assign good_mode = mode_ok(cmd.mode);
  assign has_dest  = |mask_in;
  assign go        = launch && good_mode && has_dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      vec       <= '0;
      mode      <= '0;
      trig      <= 1'b0;
      mask_q    <= '0;
      stb       <= '0;
      err_empty <= 1'b0;
      err_mode  <= 1'b0;
    end else begin
      err_mode  <= launch && !good_mode;
      err_empty <= launch && good_mode && !has_dest;
      stb       <= '0;
      if (go) begin
        valid  <= 1'b1;
        vec    <= cmd.vec;
        mode   <= cmd.mode;
        trig   <= cmd.trig;
        mask_q <= mask_in;
        stb    <= N_MODES'(1) << cmd.mode;
      end else if (valid && ready) begin
        valid  <= 1'b0;
      end
    end
  end

  // R11: a stalled request holds its payload
  p_hold_stalled_r11: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(vec) && $stable(mode)
                           && $stable(trig) && $stable(mask_q)));

  // R10: strobe is one-hot and coincides with a fresh request
  p_stb_launch_r10: assert property (@(posedge clk) disable iff (rst)
    (stb != '0) |-> (valid && $countones(stb) == 1));

  // R9: unsupported mode gives its own error and no request
  p_bad_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (launch && !good_mode && !valid) |=> (err_mode && !err_empty && !valid));

  // R8: empty destination set is rejected
  p_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (launch && good_mode && !has_dest && !valid) |=> (err_empty && !valid));

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_cmd_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int ID_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ID_W-1:0]           self_id,
  input  logic [N_UNITS-1:0]        unit_present,
  input  logic [N_UNITS-1:0]        unit_local,
  input  logic [N_UNITS*8-1:0]      unit_ldr,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic                      wr_hi,
  input  logic [31:0]               wr_data,
  output logic [31:0]               cmd_lo_q,
  output logic [31:0]               cmd_hi_q,
  output logic                      disp_valid,
  input  logic                      disp_ready,
  output logic [7:0]                disp_vector,
  output logic [2:0]                disp_mode,
  output logic                      disp_trig,
  output logic [N_UNITS-1:0]        disp_mask,
  output logic [7:0]                mode_stb,
  output logic                      err_tx_accept,
  output logic                      err_bad_mode
);

  logic               wr_fire;
  logic               send_fire;
  logic [DEST_W-1:0]  dest_id;
  cmd_t               cmd;
  logic [N_UNITS-1:0] resolved;

  assign wr_ready = !disp_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign cmd      = decode_cmd(wr_data);

  icr_word_store u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .lo_q      (cmd_lo_q),
    .hi_q      (cmd_hi_q),
    .send_fire (send_fire),
    .dest_id   (dest_id)
  );

  dest_resolve #(.N_UNITS(N_UNITS), .ID_W(ID_W)) u_dest (
    .clk      (clk),
    .rst      (rst),
    .sh       (cmd.sh),
    .logical  (cmd.logical),
    .dest     (dest_id),
    .self_id  (self_id),
    .present  (unit_present),
    .is_local (unit_local),
    .ldr      (unit_ldr),
    .mask     (resolved)
  );

  dispatch_out #(.N_UNITS(N_UNITS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .launch    (send_fire),
    .cmd       (cmd),
    .mask_in   (resolved),
    .ready     (disp_ready),
    .valid     (disp_valid),
    .vec       (disp_vector),
    .mode      (disp_mode),
    .trig      (disp_trig),
    .mask_q    (disp_mask),
    .stb       (mode_stb),
    .err_empty (err_tx_accept),
    .err_mode  (err_bad_mode)
  );

  // R3: a high-word write is silent
  p_hi_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wr_hi) |=> (!disp_valid && !err_tx_accept && !err_bad_mode));

  // R11: writes are held off while a request waits
  p_busy_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready && wr_valid) |=> $stable(cmd_lo_q) && $stable(cmd_hi_q));

endmodule

// File: tb/ipi_cmd_dispatch_tb_top.sv
module ipi_cmd_dispatch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] self_id = 8'd2;
  logic [N-1:0] present = '1;
  logic [N-1:0] is_loc = '1;
  logic [7:0] ldr [N];
  logic [N*8-1:0] ldr_flat;
  logic wr_valid = 1'b0;
  logic wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic disp_ready = 1'b1;

  logic wr_ready, disp_valid, disp_trig, err_tx_accept, err_bad_mode;
  logic [31:0] cmd_lo_q, cmd_hi_q;
  logic [7:0] disp_vector, mode_stb;
  logic [2:0] disp_mode;
  logic [N-1:0] disp_mask;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < N; i++) ldr_flat[i*8 +: 8] = ldr[i];

  ipi_cmd_dispatch #(.N_UNITS(N), .ID_W(8)) dut_i (
    .clk(clk), .rst(rst), .self_id(self_id), .unit_present(present),
    .unit_local(is_loc), .unit_ldr(ldr_flat), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_hi(wr_hi), .wr_data(wr_data),
    .cmd_lo_q(cmd_lo_q), .cmd_hi_q(cmd_hi_q), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_vector(disp_vector), .disp_mode(disp_mode),
    .disp_trig(disp_trig), .disp_mask(disp_mask), .mode_stb(mode_stb),
    .err_tx_accept(err_tx_accept), .err_bad_mode(err_bad_mode)
  );

  // reference model state
  logic m_dv, m_trig, m_ea, m_eu;
  logic [7:0] m_vec, m_stb;
  logic [2:0] m_mode;
  logic [N-1:0] m_mask;
  logic [31:0] m_lo, m_hi;

  function automatic logic [N-1:0] ref_mask(input logic [31:0] lo, input logic [31:0] hi);
    logic [N-1:0] m = '0;
    logic [7:0] d = hi[31:24];
    for (int i = 0; i < N; i++) begin
      logic hit;
      case (lo[19:18])
        2'd0: hit = lo[11] ? ((d != 0) && ((d & ldr[i]) != 0))
                           : ((d == 8'hFF) || (d == 8'(i)));
        2'd1: hit = (self_id == 8'(i));
        2'd2: hit = 1'b1;
        default: hit = (self_id != 8'(i));
      endcase
      m[i] = hit && present[i] && is_loc[i];
    end
    return m;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_dv = 0; m_trig = 0; m_ea = 0; m_eu = 0; m_vec = 0; m_stb = 0;
      m_mode = 0; m_mask = 0; m_lo = 0; m_hi = 0;
    end else begin
      logic acc;
      acc = wr_valid && !m_dv;
      if (m_dv && disp_ready) m_dv = 0;
      m_ea = 0; m_eu = 0; m_stb = 0;
      if (acc && wr_hi) m_hi = wr_data;
      else if (acc) begin
        logic [N-1:0] mk;
        m_lo = wr_data & ~32'h1000;
        if (wr_data[10:8] == 3'd2 || wr_data[10:8] == 3'd3 || wr_data[10:8] == 3'd7)
          m_eu = 1;
        else begin
          mk = ref_mask(wr_data, m_hi);
          if (mk == 0) m_ea = 1;
          else begin
            m_dv = 1; m_mask = mk; m_vec = wr_data[7:0];
            m_mode = wr_data[10:8]; m_trig = wr_data[15];
            m_stb = 8'd1 << wr_data[10:8];
          end
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      logic [127:0] act, exp;
      act = {wr_ready, disp_valid, disp_vector, disp_mode, disp_trig, disp_mask,
             mode_stb, err_tx_accept, err_bad_mode, cmd_lo_q, cmd_hi_q};
      exp = {!m_dv, m_dv, m_vec, m_mode, m_trig, m_mask,
             m_stb, m_ea, m_eu, m_lo, m_hi};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, act, exp);
      end
    end
  end

  task automatic put(input logic hi, input logic [31:0] d);
    bit ok;
    @(negedge clk);
    wr_valid = 1'b1; wr_hi = hi; wr_data = d;
    do begin
      ok = wr_ready;
      @(negedge clk);
    end while (!ok);
    wr_valid = 1'b0;
  endtask

  function automatic logic [31:0] lo(input int sh, input bit lg, input int md,
                                     input bit tr, input logic [7:0] v);
    return (32'(sh) << 18) | (32'(tr) << 15) | (32'(lg) << 11) | (32'(md) << 8) | 32'(v);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) ldr[i] = 8'd1 << i;
    ldr[5] = 8'h03;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_req = "R4";  // physical single unit, field positions
    put(1, 32'h0300_0000);
    cur_req = "R2";
    put(0, lo(0, 0, 0, 0, 8'h41));
    idle(2);
    cur_req = "R4";
    put(1, 32'hFF00_0000); put(0, lo(0, 0, 0, 1, 8'h22)); idle(2);
    cur_req = "R8";
    put(1, 32'h0900_0000); put(0, lo(0, 0, 0, 0, 8'h10)); idle(2);

    cur_req = "R5";
    put(1, 32'h0000_0000); put(0, lo(0, 1, 0, 0, 8'h30)); idle(2);
    put(1, 32'h0600_0000); put(0, lo(0, 1, 0, 0, 8'h31)); idle(2);
    put(1, 32'h8000_0000); put(0, lo(0, 1, 4, 0, 8'h32)); idle(2);

    cur_req = "R6";
    put(1, 32'h0300_0000);
    put(0, lo(1, 0, 0, 0, 8'h50)); idle(2);
    put(0, lo(2, 1, 0, 0, 8'h51)); idle(2);
    put(0, lo(3, 0, 0, 0, 8'h52)); idle(2);

    cur_req = "R7";
    present = 8'b1011_1111; is_loc = 8'b1111_1101;
    put(0, lo(2, 0, 0, 0, 8'h60)); idle(2);
    self_id = 8'd1;
    put(0, lo(1, 0, 0, 0, 8'h61)); idle(2);
    present = '1; is_loc = '1; self_id = 8'd2;

    cur_req = "R9";
    put(0, lo(0, 0, 2, 0, 8'h70)); idle(1);
    put(0, lo(0, 0, 3, 0, 8'h71)); idle(1);
    put(0, lo(0, 0, 7, 1, 8'h72)); idle(2);

    cur_req = "R10";
    put(0, lo(0, 0, 1, 1, 8'h80)); idle(1);
    put(0, lo(0, 0, 4, 0, 8'h81)); idle(1);
    put(0, lo(0, 0, 5, 1, 8'h82)); idle(1);
    put(0, lo(0, 0, 6, 0, 8'h83)); idle(2);

    cur_req = "R3";
    put(0, lo(0, 0, 0, 0, 8'h90) | 32'h0000_1000 | 32'hA000_6000); idle(2);
    put(1, 32'h0512_3456); idle(3);

    cur_req = "R11";
    disp_ready = 1'b0;
    put(0, lo(2, 0, 5, 0, 8'hA0));
    fork
      put(0, lo(0, 0, 0, 0, 8'hA1));
      begin idle(4); disp_ready = 1'b1; end
    join
    idle(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule